// File: doc/BRIEF.md
# Coherence Controller Occupancy Engine

This block models the protocol controller of one node in a cache-coherent distributed shared memory machine as a single server. Coherence messages arrive on two sides, from the local processor interface and from the network interface. Each side passes through a fixed interface delay into a bounded queue. The server takes one message at a time and stays occupied for a number of cycles that depends on the message kind and on the directory state carried in the message. It then places the message, unchanged, into the processor-side or network-side output queue. That queue releases it after a fixed outbound delay.

Service time is built from a base occupancy `o = O_BASE * OCC_MULT` (default 7 cycles), a cache retrieval cost `C` (default 15) and one cycle per invalidation. While the server is occupied, arriving messages wait. The block reports a busy flag and a running count of cycles in which a queued message waited behind a busy server, so that contention can be measured. Misses that need no communication never reach this block.

Message layout (17 bits): `[16:9]` tag, `[8:7]` kind, `[6]` dirty-in-local-cache flag, `[5:0]` invalidation count. Kind codes: 0 = issue a request to the network, 1 = reply taken in from the network, 2 = request served as home, 3 = forwarded request for a line dirty here.

Top module: `cc_occupancy_engine`

## Requirements
- R1: Every serviced message leaves unchanged. Kind 1 leaves on the processor output; kinds 0, 2 and 3 leave on the network output.
- R2: A kind 0 or kind 1 message keeps busy_o high for exactly o cycles (7 at default).
- R3: A kind 2 message keeps busy_o high for 2o cycles, plus C when the dirty bit [6] is set, plus the invalidation count in bits [5:0].
- R4: A kind 3 message keeps busy_o high for 2o + C cycles. The dirty bit and invalidation count have no effect on kinds 0, 1 and 3.
- R5: With the server idle and the queues empty, service starts 2 cycles after a processor-side message is accepted and 9 cycles after a network-side message is accepted.
- R6: With the output queue empty, a finished message appears as valid on its output 4 cycles after busy_o falls.
- R7: Each queue holds at most 16 messages, counting those inside its interface delay. A full input queue drops its ready. Accepted messages are never lost, and each queue keeps first-in first-out order. An output holds its valid and data while its ready is low.
- R8: When the destination output queue is full, the finished message is held, busy_o stays high, and no new message is started until space opens.
- R9: When both input queues hold a message as the server becomes free, the side not served by the previous grant wins. Grants alternate while both sides stay non-empty, and at most one message is taken per cycle.
- R10: A queued message starts in the same cycle the previous one finishes. busy_o then stays high without a gap, and without stalls the total busy cycles equal the sum of the service costs.
- R11: wait_cycles_o increments in every cycle in which busy_o is high and at least one input queue holds a message past its interface delay. It never changes while the server is idle.
- R12: After reset busy_o is low, wait_cycles_o is zero, both outputs are invalid and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_valid_i | input | 1 | Processor-side message valid |
| pin_msg_i | input | 17 | Processor-side message |
| pin_ready_o | output | 1 | Processor-side queue has room |
| nin_valid_i | input | 1 | Network-side message valid |
| nin_msg_i | input | 17 | Network-side message |
| nin_ready_o | output | 1 | Network-side queue has room |
| pout_valid_o | output | 1 | Processor-side result valid |
| pout_msg_o | output | 17 | Processor-side result |
| pout_ready_i | input | 1 | Processor side takes the result |
| nout_valid_o | output | 1 | Network-side result valid |
| nout_msg_o | output | 17 | Network-side result |
| nout_ready_i | input | 1 | Network side takes the result |
| busy_o | output | 1 | Server occupied |
| wait_cycles_o | output | 32 | Cycles a queued message waited behind a busy server |

## Verification
The hardest state to reach is a full backlog. The output queue and its delay stage must be full, one finished message must be held in the server, and the input queue must be full behind it. Only then does ready drop for good. The bench holds the network output ready low and pushes issue messages as fast as the input accepts them, until a send times out. The accepted count must then equal the exact capacity of the chain. The round-robin case needs both queues non-empty at the moment the server frees up. The bench gets there by loading both sides while a long home request with many invalidations occupies the server.

// File: rtl/cc_occ_pkg.sv
package cc_occ_pkg;
  localparam int TAG_W = 8;
  localparam int INV_W = 6;
  localparam int MSG_W = TAG_W + 2 + 1 + INV_W;

  typedef enum logic [1:0] {
    K_ISSUE = 2'd0,
    K_REPLY = 2'd1,
    K_HOME  = 2'd2,
    K_FWD   = 2'd3
  } kind_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    kind_e            kind;
    logic             dirty;
    logic [INV_W-1:0] inv;
  } msg_t;
endpackage

// File: rtl/cc_queue.sv
// Fixed-latency delay stages feeding a bounded FIFO; room counts in-flight stages.
module cc_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int DLY   = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         space_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         pop_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + DLY + 1);

  logic [DLY-1:0] stg_v;

  for (genvar k = 0; k < DLY; k++) begin : g_stg
    logic         v;
    logic [W-1:0] d;
    logic         nv;
    logic [W-1:0] nd;
    if (k == 0) begin : g_head
      assign nv = push_i;
      assign nd = data_i;
    end else begin : g_tail
      assign nv = g_stg[k-1].v;
      assign nd = g_stg[k-1].d;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v <= 1'b0;
        d <= '0;
      end else begin
        v <= nv;
        d <= nd;
      end
    end
    assign stg_v[k] = v;
  end

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, occ;
  logic          fpush, fpop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign fpush = g_stg[DLY-1].v;
  assign fpop  = pop_i && (cnt != '0);

  always_ff @(posedge clk_i) begin
    if (fpush) mem[wp] <= g_stg[DLY-1].d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (fpush) wp <= nxt(wp);
      if (fpop)  rp <= nxt(rp);
      cnt <= cnt + CW'(fpush) - CW'(fpop);
    end
  end

  assign occ     = cnt + CW'($countones(stg_v));
  assign space_o = occ < CW'(DEPTH);
  assign valid_o = cnt != '0;
  assign data_o  = mem[rp];
endmodule

// File: rtl/cc_service.sv
// Single server: round-robin pick, cost load, countdown, stall on full destination.
module cc_service
  import cc_occ_pkg::*;
#(
  parameter int O_BASE   = 7,
  parameter int OCC_MULT = 1,
  parameter int C_COST   = 15,
  parameter int WAIT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p_valid_i,
  input  msg_t              p_msg_i,
  output logic              p_pop_o,
  input  logic              n_valid_i,
  input  msg_t              n_msg_i,
  output logic              n_pop_o,
  input  logic              po_space_i,
  output logic              po_push_o,
  input  logic              no_space_i,
  output logic              no_push_o,
  output msg_t              res_o,
  output logic              busy_o,
  output logic [WAIT_W-1:0] wait_o
);
  localparam int OCC      = O_BASE * OCC_MULT;
  localparam int MAX_COST = 2 * OCC + C_COST + (1 << INV_W);
  localparam int CNT_W    = $clog2(MAX_COST + 1);

  function automatic logic [CNT_W-1:0] cost_of(input msg_t m);
    case (m.kind)
      K_HOME:  cost_of = CNT_W'(2 * OCC) + (m.dirty ? CNT_W'(C_COST) : CNT_W'(0))
                         + CNT_W'(m.inv);
      K_FWD:   cost_of = CNT_W'(2 * OCC + C_COST);
      default: cost_of = CNT_W'(OCC);
    endcase
  endfunction

  logic              busy_q, prio_q;
  logic [CNT_W-1:0]  cnt_q;
  msg_t              cur_q, sel;
  logic [WAIT_W-1:0] wait_q;
  logic              to_proc, dst_space, finish, free, take_p, take_n;

  assign to_proc   = cur_q.kind == K_REPLY;
  assign dst_space = to_proc ? po_space_i : no_space_i;
  assign finish    = busy_q && (cnt_q == '0) && dst_space;
  assign free      = !busy_q || finish;
  // prio_q set: network side preferred on the next contested pick
  assign take_p    = free && p_valid_i && (!n_valid_i || !prio_q);
  assign take_n    = free && n_valid_i && !take_p;
  assign sel       = take_p ? p_msg_i : n_msg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      prio_q <= 1'b0;
      cnt_q  <= '0;
      cur_q  <= '0;
      wait_q <= '0;
    end else begin
      if (take_p || take_n) begin
        cur_q  <= sel;
        cnt_q  <= cost_of(sel) - CNT_W'(1);
        busy_q <= 1'b1;
        prio_q <= take_p;
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (busy_q && (p_valid_i || n_valid_i)) wait_q <= wait_q + WAIT_W'(1);
    end
  end

  assign p_pop_o   = take_p;
  assign n_pop_o   = take_n;
  assign po_push_o = finish && to_proc;
  assign no_push_o = finish && !to_proc;
  assign res_o     = cur_q;
  assign busy_o    = busy_q;
  assign wait_o    = wait_q;
endmodule

// File: rtl/cc_occupancy_engine.sv
module cc_occupancy_engine
  import cc_occ_pkg::*;
#(
  parameter int O_BASE   = 7,
  parameter int OCC_MULT = 1,
  parameter int C_COST   = 15,
  parameter int Q_DEPTH  = 16,
  parameter int PIN_DLY  = 1,
  parameter int POUT_DLY = 4,
  parameter int NIN_DLY  = 8,
  parameter int NOUT_DLY = 4,
  parameter int WAIT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_valid_i,
  input  logic [MSG_W-1:0] pin_msg_i,
  output logic             pin_ready_o,
  input  logic             nin_valid_i,
  input  logic [MSG_W-1:0] nin_msg_i,
  output logic             nin_ready_o,
  output logic             pout_valid_o,
  output logic [MSG_W-1:0] pout_msg_o,
  input  logic             pout_ready_i,
  output logic             nout_valid_o,
  output logic [MSG_W-1:0] nout_msg_o,
  input  logic             nout_ready_i,
  output logic             busy_o,
  output logic [WAIT_W-1:0] wait_cycles_o
);
  msg_t p_msg, n_msg, res;
  logic p_v, n_v, p_pop, n_pop;
  logic po_push, no_push, po_space, no_space;

  cc_queue #(.W(MSG_W), .DEPTH(Q_DEPTH), .DLY(PIN_DLY)) u_pin_q (
    .clk_i, .rst_ni,
    .push_i (pin_valid_i && pin_ready_o), .data_i(pin_msg_i), .space_o(pin_ready_o),
    .valid_o(p_v), .data_o(p_msg), .pop_i(p_pop)
  );

  cc_queue #(.W(MSG_W), .DEPTH(Q_DEPTH), .DLY(NIN_DLY)) u_nin_q (
    .clk_i, .rst_ni,
    .push_i (nin_valid_i && nin_ready_o), .data_i(nin_msg_i), .space_o(nin_ready_o),
    .valid_o(n_v), .data_o(n_msg), .pop_i(n_pop)
  );

  cc_service #(
    .O_BASE(O_BASE), .OCC_MULT(OCC_MULT), .C_COST(C_COST), .WAIT_W(WAIT_W)
  ) u_svc (
    .clk_i, .rst_ni,
    .p_valid_i(p_v), .p_msg_i(p_msg), .p_pop_o(p_pop),
    .n_valid_i(n_v), .n_msg_i(n_msg), .n_pop_o(n_pop),
    .po_space_i(po_space), .po_push_o(po_push),
    .no_space_i(no_space), .no_push_o(no_push),
    .res_o(res), .busy_o(busy_o), .wait_o(wait_cycles_o)
  );

  cc_queue #(.W(MSG_W), .DEPTH(Q_DEPTH), .DLY(POUT_DLY)) u_pout_q (
    .clk_i, .rst_ni,
    .push_i(po_push), .data_i(res), .space_o(po_space),
    .valid_o(pout_valid_o), .data_o(pout_msg_o), .pop_i(pout_ready_i)
  );

  cc_queue #(.W(MSG_W), .DEPTH(Q_DEPTH), .DLY(NOUT_DLY)) u_nout_q (
    .clk_i, .rst_ni,
    .push_i(no_push), .data_i(res), .space_o(no_space),
    .valid_o(nout_valid_o), .data_o(nout_msg_o), .pop_i(nout_ready_i)
  );
endmodule

// File: rtl/cc_occupancy_engine_chk.sv
module cc_occupancy_engine_chk
  import cc_occ_pkg::*;
#(
  parameter int WAIT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              p_pop_i,
  input logic              n_pop_i,
  input logic              po_push_i,
  input logic              po_space_i,
  input logic              no_push_i,
  input logic              no_space_i,
  input logic              pout_valid_i,
  input logic              pout_ready_i,
  input logic [MSG_W-1:0]  pout_msg_i,
  input logic              nout_valid_i,
  input logic              nout_ready_i,
  input logic [MSG_W-1:0]  nout_msg_i,
  input logic              busy_i,
  input logic [WAIT_W-1:0] wait_i
);
  a_r9_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({p_pop_i, n_pop_i}));

  a_r8_pout_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    po_push_i |-> po_space_i);

  a_r8_nout_push_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_push_i |-> no_space_i);

  a_r7_pout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pout_valid_i && !pout_ready_i |=> pout_valid_i && $stable(pout_msg_i));

  a_r7_nout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nout_valid_i && !nout_ready_i |=> nout_valid_i && $stable(nout_msg_i));

  a_r10_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_pop_i || n_pop_i) |=> busy_i);

  a_r11_wait_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(wait_i));
endmodule

bind cc_occupancy_engine cc_occupancy_engine_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .p_pop_i     (p_pop),
  .n_pop_i     (n_pop),
  .po_push_i   (po_push),
  .po_space_i  (po_space),
  .no_push_i   (no_push),
  .no_space_i  (no_space),
  .pout_valid_i(pout_valid_o),
  .pout_ready_i(pout_ready_i),
  .pout_msg_i  (pout_msg_o),
  .nout_valid_i(nout_valid_o),
  .nout_ready_i(nout_ready_i),
  .nout_msg_i  (nout_msg_o),
  .busy_i      (busy_o),
  .wait_i      (wait_cycles_o)
);

// File: tb/cc_occupancy_engine_tb.sv
module cc_occupancy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_v, nin_v, pin_rdy, nin_rdy;
  logic [16:0] pin_m, nin_m, pout_m, nout_m;
  logic        pout_v, nout_v, pout_r, nout_r;
  logic        busy;
  logic [31:0] waitc;

  int checks = 0, errors = 0, cyc = 0;
  int busy_total = 0;
  int log_tag [1024];
  int log_port [1024];
  int log_kind [1024];
  int log_n = 0;
  bit hold_pr = 1'b1, hold_nr = 1'b1, rnd_ready = 1'b0;
  int sum_cost;
  int unsigned seed_init;

  always #5 clk = ~clk;

  cc_occupancy_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pin_valid_i(pin_v), .pin_msg_i(pin_m), .pin_ready_o(pin_rdy),
    .nin_valid_i(nin_v), .nin_msg_i(nin_m), .nin_ready_o(nin_rdy),
    .pout_valid_o(pout_v), .pout_msg_o(pout_m), .pout_ready_i(pout_r),
    .nout_valid_o(nout_v), .nout_msg_o(nout_m), .nout_ready_i(nout_r),
    .busy_o(busy), .wait_cycles_o(waitc)
  );

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    pout_r <= rnd_ready ? ($urandom % 4 != 0) : hold_pr;
    nout_r <= rnd_ready ? ($urandom % 3 != 0) : hold_nr;
  end

  always @(negedge clk) begin
    if (busy === 1'b1) busy_total++;
    if (pout_v === 1'b1 && pout_r === 1'b1 && log_n < 1024) begin
      log_tag[log_n] = int'(pout_m[16:9]); log_port[log_n] = 0;
      log_kind[log_n] = int'(pout_m[8:7]); log_n++;
    end
    if (nout_v === 1'b1 && nout_r === 1'b1 && log_n < 1024) begin
      log_tag[log_n] = int'(nout_m[16:9]); log_port[log_n] = 1;
      log_kind[log_n] = int'(nout_m[8:7]); log_n++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual cycle %0d expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input int tag, input int kind, input int dirty, input int inv);
    return {8'(tag), 2'(kind), 1'(dirty), 6'(inv)};
  endfunction

  function automatic int exp_cost(input int kind, input int dirty, input int inv);
    int o = 7;
    case (kind)
      2: return 2 * o + (dirty != 0 ? 15 : 0) + inv;
      3: return 2 * o + 15;
      default: return o;
    endcase
  endfunction

  // called just after a falling edge; returns just after a falling edge
  task automatic send(input bit net, input logic [16:0] m, output int acc, output bit ok);
    ok = 1'b0; acc = -1;
    if (net) begin nin_v = 1'b1; nin_m = m; end
    else     begin pin_v = 1'b1; pin_m = m; end
    for (int k = 0; k < 400 && !ok; k++) begin
      if (net ? nin_rdy : pin_rdy) ok = 1'b1;
      @(negedge clk);
    end
    if (ok) acc = cyc;
    if (net) nin_v = 1'b0; else pin_v = 1'b0;
  endtask

  task automatic wait_busy(input bit lvl, input int lim);
    for (int k = 0; k < lim && busy !== lvl; k++) @(negedge clk);
  endtask

  task automatic iso(input string req, input bit net, input int tag, input int kind,
                     input int dirty, input int inv);
    int acc, rise, fall, w0;
    bit ok;
    logic [16:0] m;
    m = mk(tag, kind, dirty, inv);
    w0 = int'(waitc);
    send(net, m, acc, ok);
    check("R7 accepted", int'(ok), 1);
    wait_busy(1'b1, 100);
    rise = cyc;
    check("R5 start delay", rise - acc, net ? 9 : 2);
    wait_busy(1'b0, 300);
    fall = cyc;
    check(req, fall - rise, exp_cost(kind, dirty, inv));
    for (int k = 0; k < 20 && !(kind == 1 ? pout_v : nout_v); k++) @(negedge clk);
    check("R6 output delay", cyc - fall, 4);
    check("R1 output data", int'(kind == 1 ? pout_m : nout_m), int'(m));
    check("R1 other port idle", int'(kind == 1 ? nout_v : pout_v), 0);
    check("R11 no wait alone", int'(waitc) - w0, 0);
    @(negedge clk);
  endtask

  task automatic verify_log(input string req, input int l0, input int n, input int lo);
    int seen [256];
    int bad_port = 0, uniq = 0;
    for (int i = 0; i < 256; i++) seen[i] = 0;
    for (int i = l0; i < l0 + n; i++) begin
      if ((log_kind[i] == 1 ? 0 : 1) != log_port[i]) bad_port++;
      if (log_tag[i] >= lo && log_tag[i] < lo + n && seen[log_tag[i]] == 0) uniq++;
      seen[log_tag[i]]++;
    end
    check("R1 routing by kind", bad_port, 0);
    check(req, uniq, n);
  endtask

  task automatic rand_phase(input int lo, input int n_side, input int inv_mod, input int lim);
    int l0;
    l0 = log_n;
    fork
      begin
        for (int i = 0; i < n_side; i++) begin
          int a, kd, dt, iv; bit ok;
          kd = int'($urandom % 4); dt = int'($urandom % 2); iv = int'($urandom % inv_mod);
          sum_cost += exp_cost(kd, dt, iv);
          send(1'b0, mk(lo + i, kd, dt, iv), a, ok);
          repeat ($urandom % 4) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < n_side; i++) begin
          int a, kd, dt, iv; bit ok;
          kd = int'($urandom % 4); dt = int'($urandom % 2); iv = int'($urandom % inv_mod);
          sum_cost += exp_cost(kd, dt, iv);
          send(1'b1, mk(lo + n_side + i, kd, dt, iv), a, ok);
          repeat ($urandom % 4) @(negedge clk);
        end
      end
    join
    for (int k = 0; k < lim && (log_n - l0 < 2 * n_side || busy); k++) @(negedge clk);
    verify_log("R7 all delivered once", l0, 2 * n_side, lo);
  endtask

  initial begin
    int g, a, l0, sent, w0, bt0;
    bit ok;
    seed_init = $urandom(32'd1967);
    rst_n = 1'b0; pin_v = 1'b0; nin_v = 1'b0; pin_m = '0; nin_m = '0;
    repeat (3) @(negedge clk);
    check("R12 busy reset", int'(busy), 0);
    check("R12 wait reset", int'(waitc), 0);
    check("R12 pout invalid", int'(pout_v), 0);
    check("R12 nout invalid", int'(nout_v), 0);
    check("R12 pin ready", int'(pin_rdy), 1);
    check("R12 nin ready", int'(nin_rdy), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // isolated costs, delays and routing
    iso("R2 issue cost",          1'b0, 1, 0, 0, 0);
    iso("R2 reply cost",          1'b1, 2, 1, 0, 0);
    iso("R4 issue ignores fields",1'b0, 3, 0, 1, 5);
    iso("R3 home clean",          1'b0, 4, 2, 0, 0);
    iso("R3 home dirty",          1'b0, 5, 2, 1, 0);
    iso("R3 home dirty inv",      1'b1, 6, 2, 1, 3);
    iso("R3 home max inv",        1'b0, 7, 2, 0, 63);
    iso("R4 forward cost",        1'b1, 8, 3, 0, 9);
    iso("R4 reply ignores fields",1'b0, 9, 1, 1, 7);

    // contention count behind a blocker
    w0 = int'(waitc);
    send(1'b0, mk(20, 2, 1, 20), a, ok);
    wait_busy(1'b1, 100);
    g = cyc;
    send(1'b0, mk(21, 0, 0, 0), a, ok);
    wait_busy(1'b0, 300);
    check("R10 back to back busy", cyc - g, 49 + 7);
    check("R11 wait cycles", int'(waitc) - w0, g + 48 - a);
    repeat (12) @(negedge clk);

    // round-robin with both queues loaded
    l0 = log_n;
    send(1'b0, mk(30, 2, 1, 40), a, ok);
    wait_busy(1'b1, 100);
    g = cyc;
    fork
      for (int i = 0; i < 3; i++) begin int aa; bit okk; send(1'b0, mk(40 + i, 0, 0, 0), aa, okk); end
      for (int i = 0; i < 3; i++) begin int aa; bit okk; send(1'b1, mk(50 + i, 1, 0, 0), aa, okk); end
    join
    wait_busy(1'b0, 400);
    check("R10 continuous busy", cyc - g, 69 + 6 * 7);
    repeat (12) @(negedge clk);
    check("R9 output count", log_n - l0, 7);
    check("R9 order 0", log_tag[l0 + 0], 30);
    check("R9 order 1", log_tag[l0 + 1], 50);
    check("R9 order 2", log_tag[l0 + 2], 40);
    check("R9 order 3", log_tag[l0 + 3], 51);
    check("R9 order 4", log_tag[l0 + 4], 41);
    check("R9 order 5", log_tag[l0 + 5], 52);
    check("R9 order 6", log_tag[l0 + 6], 42);

    // full backlog behind a stalled network output
    hold_nr = 1'b0;
    repeat (2) @(negedge clk);
    l0 = log_n; sent = 0;
    for (int i = 0; i < 40; i++) begin
      send(1'b0, mk(100 + i, 0, 0, 0), a, ok);
      if (!ok) break;
      sent++;
    end
    check("R7 backlog capacity", sent, 33);
    check("R8 busy while stalled", int'(busy), 1);
    check("R7 head held valid", int'(nout_v), 1);
    check("R7 head data", int'(nout_m), int'(mk(100, 0, 0, 0)));
    check("R8 nothing released", log_n - l0, 0);
    w0 = int'(waitc);
    repeat (10) @(negedge clk);
    check("R8 still busy", int'(busy), 1);
    check("R11 wait grows in stall", int'(waitc) - w0, 10);
    hold_nr = 1'b1;
    for (int k = 0; k < 2000 && (log_n - l0 < 33 || busy); k++) @(negedge clk);
    check("R7 backlog drained", log_n - l0, 33);
    begin
      int bad = 0;
      for (int i = 0; i < 33; i++) if (log_tag[l0 + i] != 100 + i) bad++;
      check("R7 FIFO order", bad, 0);
    end
    repeat (5) @(negedge clk);

    // random traffic, free outputs: busy total equals cost sum
    bt0 = busy_total; sum_cost = 0;
    rand_phase(150, 30, 16, 8000);
    check("R10 busy equals cost sum", busy_total - bt0, sum_cost);

    // random traffic under random output backpressure
    rnd_ready = 1'b1;
    sum_cost = 0;
    rand_phase(0, 30, 64, 30000);
    rnd_ready = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 idle after traffic", int'(busy), 0);

    summary();
    $finish;
  end
endmodule